// File: doc/BRIEF.md
# Serial Delay Register Programming Interface

This block programs a bank of per-channel timing settings from a slow three-wire serial link. A host drives a data line, a select line and an update line, all qualified by a serial clock. While select is high, each rising serial-clock edge shifts one data bit into a 16-bit word, least significant bit first. When the host raises update together with the last bit, the register named by the word follows the shifted data while the serial clock is high. It keeps that value from the falling serial-clock edge.

The bank serves four channels. Each channel has three settings. The first is a 6-bit coarse delay code. The second is a 6-bit fine delay code with an enable. The third is a 7-bit falling-edge trim code with an enable. Word bits 6:0 carry data, bit 10 carries the enable, and bits 7 to 9 are don't-care. Bits 12:11 pick the function: 0 is coarse, 1 is fine, 2 is falling-edge trim and 3 is unused. Bits 14:13 pick the channel. Bit 15 set high broadcasts the chosen function to all four channels. All serial inputs are resynchronised into the system clock through two-flop synchronisers. The serial clock edges are detected from the synchronised copy. All register contents are presented in parallel to the delay hardware.

Top module: `dly_prog_if`

## Requirements
- R1: A synchronous active-high reset clears every code, every enable and the shift word to zero.
- R2: The shift word advances only on a serial-clock rising edge while select is high; serial-clock pulses with select low leave the shifted word unchanged.
- R3: A write with function 0 loads word bits 5:0 into the addressed channel's coarse code; word bit 6 is dropped.
- R4: A write with function 1 loads word bits 5:0 into the fine code and word bit 10 into the fine enable.
- R5: A write with function 2 loads word bits 6:0 into the falling-edge code and word bit 10 into its enable; word bits 9:7 have no effect.
- R6: A write with function 3 changes no register.
- R7: A single (non-broadcast) write changes only the register of the channel in word bits 14:13.
- R8: With word bit 15 high, the function in bits 12:11 is written in all four channels at once.
- R9: Shifting a full word without raising update changes no register.
- R10: While the serial clock is high with select and update high, the addressed register already shows the new value, and it keeps that value after the serial clock falls and update drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial clock (asynchronous) |
| ser_din | input | 1 | Serial data, LSB first |
| ser_cs | input | 1 | Serial select, high enables shifting |
| ser_upd | input | 1 | Update, opens the addressed register while ser_clk is high |
| crs_code | output | 24 | Coarse codes, channel c at [6c+5:6c] |
| fin_code | output | 24 | Fine codes, channel c at [6c+5:6c] |
| fin_en | output | 4 | Fine enables, one per channel |
| fea_code | output | 28 | Falling-edge codes, channel c at [7c+6:7c] |
| fea_en | output | 4 | Falling-edge enables, one per channel |

## Verification
Each serial level takes two system-clock edges to cross the synchroniser and one more to be seen as held. A register therefore takes the new value on the fourth system-clock edge after the serial clock goes high with update. It freezes within three edges after the serial clock falls. The bench holds every serial-clock phase for at least four system clocks, and the high phase for eight. It probes the open register seven cycles into the final high phase. The scoreboard entry for a word is compared only after six settling cycles past the last falling edge, and before the next word starts.

// File: rtl/dly_prog_if.sv
module dly_prog_if #(
  parameter int CW = 6,
  parameter int FW = 6,
  parameter int EW = 7
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ser_clk,
  input  logic            ser_din,
  input  logic            ser_cs,
  input  logic            ser_upd,
  output logic [4*CW-1:0] crs_code,
  output logic [4*FW-1:0] fin_code,
  output logic [3:0]      fin_en,
  output logic [4*EW-1:0] fea_code,
  output logic [3:0]      fea_en
);
  localparam int NCH = 4;
  localparam int WW  = 16;
  localparam int ENB = 10;

  logic [2:0]    ck_p;
  logic [1:0]    di_p, cs_p, up_p;
  logic [WW-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      ck_p <= '0;
      di_p <= '0;
      cs_p <= '0;
      up_p <= '0;
    end else begin
      ck_p <= {ck_p[1:0], ser_clk};
      di_p <= {di_p[0], ser_din};
      cs_p <= {cs_p[0], ser_cs};
      up_p <= {up_p[0], ser_upd};
    end
  end

  wire ck_rise = ck_p[1] & ~ck_p[2];
  wire wr_open = ck_p[1] & ck_p[2] & cs_p[1] & up_p[1];

  always_ff @(posedge clk) begin
    if (rst)                   sh <= '0;
    else if (ck_rise && cs_p[1]) sh <= {di_p[1], sh[WW-1:1]};
  end

  wire [1:0] fn    = sh[12:11];
  wire [1:0] ch    = sh[14:13];
  wire       bcast = sh[15];
  wire       en    = sh[ENB];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    wire hit = wr_open & (bcast | (ch == 2'(c)));
    always_ff @(posedge clk) begin
      if (rst) begin
        crs_code[c*CW +: CW] <= '0;
        fin_code[c*FW +: FW] <= '0;
        fin_en[c]            <= 1'b0;
        fea_code[c*EW +: EW] <= '0;
        fea_en[c]            <= 1'b0;
      end else if (hit) begin
        case (fn)
          2'd0: crs_code[c*CW +: CW] <= sh[CW-1:0];
          2'd1: begin
            fin_code[c*FW +: FW] <= sh[FW-1:0];
            fin_en[c]            <= en;
          end
          2'd2: begin
            fea_code[c*EW +: EW] <= sh[EW-1:0];
            fea_en[c]            <= en;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/dly_prog_if_chk.sv
module dly_prog_if_chk (
  input logic        clk,
  input logic        rst,
  input logic        ser_clk,
  input logic        ser_cs,
  input logic        ser_upd,
  input logic [23:0] crs_code,
  input logic [23:0] fin_code,
  input logic [3:0]  fin_en,
  input logic [27:0] fea_code,
  input logic [3:0]  fea_en
);
  wire [83:0] regs = {crs_code, fin_code, fin_en, fea_code, fea_en};

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (regs == '0));

  assert_no_upd_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!ser_upd && !$past(ser_upd) && !$past(ser_upd, 2) && !$past(ser_upd, 3))
      |-> $stable(regs));

  assert_no_cs_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!ser_cs && !$past(ser_cs) && !$past(ser_cs, 2) && !$past(ser_cs, 3))
      |-> $stable(regs));

  assert_ck_low_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (!ser_clk && !$past(ser_clk) && !$past(ser_clk, 2) && !$past(ser_clk, 3))
      |-> $stable(regs));
endmodule

bind dly_prog_if dly_prog_if_chk u_chk (
  .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_cs(ser_cs), .ser_upd(ser_upd),
  .crs_code(crs_code), .fin_code(fin_code), .fin_en(fin_en),
  .fea_code(fea_code), .fea_en(fea_en)
);

// File: tb/dly_prog_if_tb.sv
module dly_prog_if_tb;
  logic clk = 0, rst = 1;
  logic ser_clk = 0, ser_din = 0, ser_cs = 0, ser_upd = 0;
  logic [23:0] crs_code, fin_code;
  logic [3:0]  fin_en, fea_en;
  logic [27:0] fea_code;

  always #2.5 clk = ~clk;

  dly_prog_if u_dut (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_din(ser_din),
    .ser_cs(ser_cs), .ser_upd(ser_upd), .crs_code(crs_code),
    .fin_code(fin_code), .fin_en(fin_en), .fea_code(fea_code), .fea_en(fea_en)
  );

  int checks = 0, fails = 0;
  logic [5:0] m_crs [4];
  logic [5:0] m_fin [4];
  logic       m_fen [4];
  logic [6:0] m_fea [4];
  logic       m_aen [4];
  logic [83:0] exp_q [$];
  string       tag_q [$];
  logic        done = 0;

  function automatic logic [83:0] snap_model();
    logic [83:0] v = '0;
    for (int c = 0; c < 4; c++) begin
      v[60 + c*6 +: 6] = m_crs[c];
      v[36 + c*6 +: 6] = m_fin[c];
      v[32 + c]        = m_fen[c];
      v[4 + c*7 +: 7]  = m_fea[c];
      v[c]             = m_aen[c];
    end
    return v;
  endfunction

  function automatic logic [83:0] snap_dut();
    return {crs_code, fin_code, fin_en, fea_code, fea_en};
  endfunction

  function automatic logic [15:0] mk(bit all, int ch, int fn, bit en, logic [2:0] junk, logic [6:0] d);
    return {all, 2'(ch), 2'(fn), en, junk, d};
  endfunction

  task automatic model_write(logic [15:0] w);
    for (int c = 0; c < 4; c++) begin
      if (w[15] || w[14:13] == 2'(c)) begin
        case (w[12:11])
          2'd0: m_crs[c] = w[5:0];
          2'd1: begin m_fin[c] = w[5:0]; m_fen[c] = w[10]; end
          2'd2: begin m_fea[c] = w[6:0]; m_aen[c] = w[10]; end
          default: ;
        endcase
      end
    end
  endtask

  task automatic check(string tag, logic [83:0] act, logic [83:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic send_word(logic [15:0] w, bit upd, bit noise, string tag, bit peek);
    ser_cs = 1;
    for (int b = 0; b < 16; b++) begin
      ser_din = w[b];
      if (b == 15 && upd) ser_upd = 1;
      repeat (4) @(posedge clk);
      ser_clk = 1;
      if (b == 15 && upd) begin
        model_write(w);
        repeat (7) @(posedge clk);
        @(negedge clk);
        if (peek) check({tag, " open"}, snap_dut(), snap_model());
        @(posedge clk);
      end else repeat (8) @(posedge clk);
      ser_clk = 0;
      repeat (4) @(posedge clk);
      if (noise && b < 15) begin
        ser_cs = 0; ser_din = ~ser_din;
        repeat (4) @(posedge clk); ser_clk = 1;
        repeat (8) @(posedge clk); ser_clk = 0;
        repeat (4) @(posedge clk); ser_cs = 1;
      end
    end
    ser_upd = 0; ser_cs = 0;
    repeat (6) @(posedge clk);
    exp_q.push_back(snap_model());
    tag_q.push_back(tag);
    repeat (3) @(posedge clk);
  endtask

  always @(negedge clk) begin
    if (exp_q.size() > 0) check(tag_q.pop_front(), snap_dut(), exp_q.pop_front());
  end

  initial begin
    for (int c = 0; c < 4; c++) begin
      m_crs[c] = 0; m_fin[c] = 0; m_fen[c] = 0; m_fea[c] = 0; m_aen[c] = 0;
    end
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R1 reset", snap_dut(), '0);
    rst = 0;
    repeat (3) @(posedge clk);
    send_word(mk(0, 0, 0, 0, 3'b000, 7'h2A), 1, 0, "R3 coarse ch0", 0);
    send_word(mk(0, 2, 0, 1, 3'b101, 7'h7F), 1, 0, "R3 coarse bit6 dropped", 0);
    send_word(mk(0, 1, 1, 1, 3'b000, 7'h15), 1, 0, "R4 fine ch1", 0);
    send_word(mk(0, 2, 2, 1, 3'b111, 7'h5B), 1, 0, "R5 fea ch2 junk", 0);
    send_word(mk(0, 3, 3, 1, 3'b111, 7'h7F), 1, 0, "R6 unused slot", 0);
    send_word(mk(0, 3, 0, 0, 3'b000, 7'h3F), 1, 0, "R7 coarse ch3 only", 0);
    send_word(mk(0, 0, 0, 0, 3'b000, 7'h01), 0, 0, "R9 no update", 0);
    send_word(mk(1, 0, 1, 1, 3'b000, 7'h0C), 1, 0, "R8 broadcast fine", 0);
    send_word(mk(1, 2, 0, 0, 3'b010, 7'h11), 1, 1, "R2 R8 cs-low noise bcast coarse", 0);
    send_word(mk(0, 0, 2, 1, 3'b000, 7'h7F), 1, 0, "R10 fea ch0", 1);
    send_word(mk(0, 1, 1, 0, 3'b000, 7'h00), 1, 0, "R4 fine enable clear", 0);
    send_word(mk(1, 1, 3, 1, 3'b000, 7'h55), 1, 0, "R6 R8 broadcast unused", 0);
    rst = 1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1 reset after writes", snap_dut(), '0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule